// File: doc/BRIEF.md
# Two-Bit Hardware Cursor Overlay

This block lays a small hardware cursor over a stream of 24-bit RGB pixels. Each incoming pixel carries its raster column and row, a valid flag and the background colour. The block decides whether that raster point falls inside the 64x64 cursor square and, if so, looks up a 2-bit pixel index in an internal pattern store. A zero index leaves the background as it is. A non-zero index replaces the background with one of three cursor colours. The mixed pixel comes out exactly two clock cycles later, with its valid flag delayed by the same amount.

The cursor image, the three colours and the cursor position are all loaded through a write-only register port. The position holds two 12-bit two's-complement coordinates. The cursor can therefore sit partly off the left or top edge of the screen, and only its visible part is drawn. A display control word is an input. The cursor is shown only while the top nine bits of that word are all zero.

Top module: `hwc_overlay`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` and `out_pixel` are zero. Reset also clears the position register, the three colour registers and every pattern word to zero.
- R2: `out_valid` follows `pix_valid` with a delay of exactly two clock cycles. `out_pixel` is the result for the pixel that was presented two cycles earlier.
- R3: A pixel outside the cursor square is passed through unchanged as `pix_bg`.
- R4: A pixel inside the square whose pattern index is 0 is transparent, so the output is `pix_bg`.
- R5: A pixel inside the square whose index is n (1 to 3) is replaced by colour register n. A colour register holds red in bits 7:0, green in bits 15:8 and blue in bits 23:16 of its 24-bit value.
- R6: Cursor line L, column C (0..63) uses pattern word L*8 + C/8. Within that 16-bit word, pixel C%8 takes bits [2*(C%8)+1 : 2*(C%8)], so the lowest bit pair is the leftmost pixel.
- R7: The position register holds cursor x in bits 23:12 and cursor y in bits 11:0. Both are 12-bit two's complement. With a negative x or y, the rows and columns that fall at raster coordinates below zero are simply never drawn.
- R8: The cursor is drawn only when `disp_ctrl[31:23]` is all zero. A set bit anywhere in that field makes every pixel pass through as background. Bits 22:0 have no effect.
- R9: A raster point (rx, ry) is inside the square exactly when 0 <= rx - x <= 63 and 0 <= ry - y <= 63.
- R10: The register map is as follows. Addresses 0x000 to 0x1FF write pattern word `reg_addr` from `reg_wdata[15:0]`. Address 0x200 writes the position from `reg_wdata[23:0]`. Addresses 0x201 to 0x203 write colours 1 to 3 from `reg_wdata[23:0]`. Writes to any other address with bit 9 set are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register write address |
| reg_wdata | input | 32 | Register write data |
| disp_ctrl | input | 32 | Display control word; bits 31:23 gate the cursor |
| pix_valid | input | 1 | Input pixel valid |
| pix_x | input | 12 | Raster column of the input pixel |
| pix_y | input | 12 | Raster row of the input pixel |
| pix_bg | input | 24 | Background colour of the input pixel |
| out_valid | output | 1 | Output pixel valid, two cycles after `pix_valid` |
| out_pixel | output | 24 | Mixed output pixel |

## Verification
The bench builds the block with its default parameters: a 64x64 cursor, 2-bit indices, 16-bit pattern words and 12-bit coordinates. With these sizes, every corner of the cursor square and both sides of each window edge can be reached with a handful of raster points. The 12-bit signed position lets small negative offsets exercise a cursor that hangs off the top-left corner. The pattern words that are loaded cover all four bit pairs and the first and last words of the store, which checks the pixel ordering and the line stride.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

    // Register window split: the top address bit selects the space.
    typedef enum logic {
        HWC_SPACE_PATTERN = 1'b0,
        HWC_SPACE_MISC    = 1'b1
    } hwc_space_e;

    // Selector value of the position register inside the misc space;
    // non-zero selectors address the colour registers.
    localparam int unsigned HWC_POS_SEL = 0;

endpackage

// File: rtl/hwc_pattern_store.sv
module hwc_pattern_store #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned DEPTH  = 512,
    parameter int unsigned AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/hwc_hit_test.sv
module hwc_hit_test #(
    parameter int unsigned COORD_W = 12,
    parameter int unsigned OFS_W   = 6
) (
    input  logic                 en,
    input  logic [COORD_W-1:0]   rx,
    input  logic [COORD_W-1:0]   ry,
    input  logic [2*COORD_W-1:0] pos,
    output logic                 hit,
    output logic [OFS_W-1:0]     col,
    output logic [OFS_W-1:0]     row
);

    localparam int unsigned DIFF_W = COORD_W + 2;

    logic [COORD_W-1:0] pos_x, pos_y;
    logic [DIFF_W-1:0]  dx, dy;
    logic               in_x, in_y;

    assign pos_x = pos[2*COORD_W-1:COORD_W];
    assign pos_y = pos[COORD_W-1:0];

    // Raster coordinates are unsigned; cursor coordinates are signed.
    assign dx = {2'b00, rx} - {{2{pos_x[COORD_W-1]}}, pos_x};
    assign dy = {2'b00, ry} - {{2{pos_y[COORD_W-1]}}, pos_y};

    // Non-negative and below the power-of-two cursor size.
    assign in_x = (dx[DIFF_W-1:OFS_W] == '0);
    assign in_y = (dy[DIFF_W-1:OFS_W] == '0);

    assign hit = en && in_x && in_y;
    assign col = dx[OFS_W-1:0];
    assign row = dy[OFS_W-1:0];

endmodule

// File: rtl/hwc_pixel_pick.sv
module hwc_pixel_pick #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned PPW    = WORD_W / IDX_W,
    parameter int unsigned SUB_W  = $clog2(PPW)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [SUB_W-1:0]  sel,
    output logic [IDX_W-1:0]  idx
);

    logic [IDX_W-1:0] lane [PPW];

    // Leftmost pixel sits in the least significant bit pair.
    for (genvar g = 0; g < PPW; g++) begin : g_lane
        assign lane[g] = word[g*IDX_W +: IDX_W];
    end

    assign idx = lane[sel];

endmodule

// File: rtl/hwc_overlay.sv
module hwc_overlay
    import hwc_pkg::*;
#(
    parameter  int unsigned CUR_DIM = 64,
    parameter  int unsigned IDX_W   = 2,
    parameter  int unsigned WORD_W  = 16,
    parameter  int unsigned COORD_W = 12,
    parameter  int unsigned COLOR_W = 24,
    parameter  int unsigned DATA_W  = 32,
    parameter  int unsigned EN_LSB  = 23,
    localparam int unsigned PPW     = WORD_W / IDX_W,
    localparam int unsigned WPL     = CUR_DIM / PPW,
    localparam int unsigned DEPTH   = CUR_DIM * WPL,
    localparam int unsigned OFS_W   = $clog2(CUR_DIM),
    localparam int unsigned SUB_W   = $clog2(PPW),
    localparam int unsigned WADDR_W = $clog2(DEPTH),
    localparam int unsigned RADDR_W = WADDR_W + 1,
    localparam int unsigned NUM_COL = (1 << IDX_W) - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic [DATA_W-1:0]  disp_ctrl,
    input  logic               pix_valid,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [COLOR_W-1:0] pix_bg,
    output logic               out_valid,
    output logic [COLOR_W-1:0] out_pixel
);

    typedef struct packed {
        logic               valid;
        logic               hit;
        logic [OFS_W-1:0]   col;
        logic [OFS_W-1:0]   row;
        logic [COLOR_W-1:0] bg;
    } s1_t;

    typedef struct packed {
        logic [2*COORD_W-1:0]            pos;
        logic [NUM_COL-1:0][COLOR_W-1:0] colour;
        s1_t                             s1;
        logic                            out_valid;
        logic [COLOR_W-1:0]              out_pixel;
    } state_t;

    state_t st_d, st_q;

    // Register port decode
    hwc_space_e          space;
    logic [WADDR_W-1:0]  sub_addr;
    logic [IDX_W-1:0]    misc_sel;
    logic                misc_we, pat_we;

    assign space    = hwc_space_e'(reg_addr[RADDR_W-1]);
    assign sub_addr = reg_addr[WADDR_W-1:0];
    assign misc_sel = sub_addr[IDX_W-1:0];
    assign misc_we  = reg_we && (space == HWC_SPACE_MISC)
                      && (sub_addr[WADDR_W-1:IDX_W] == '0);
    assign pat_we   = reg_we && (space == HWC_SPACE_PATTERN);

    // Stage 1: window test
    logic               cursor_en;
    logic               hit_w;
    logic [OFS_W-1:0]   col_w, row_w;

    assign cursor_en = (disp_ctrl[DATA_W-1:EN_LSB] == '0);

    hwc_hit_test #(
        .COORD_W (COORD_W),
        .OFS_W   (OFS_W)
    ) u_hit (
        .en  (cursor_en),
        .rx  (pix_x),
        .ry  (pix_y),
        .pos (st_q.pos),
        .hit (hit_w),
        .col (col_w),
        .row (row_w)
    );

    // Stage 2: pattern read and index extraction
    logic [WADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0]  rd_word;
    logic [IDX_W-1:0]   pick_idx;

    assign rd_addr = {st_q.s1.row, st_q.s1.col[OFS_W-1:SUB_W]};

    hwc_pattern_store #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH),
        .AW     (WADDR_W)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (pat_we),
        .waddr (sub_addr),
        .wdata (reg_wdata[WORD_W-1:0]),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    hwc_pixel_pick #(
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W),
        .PPW    (PPW),
        .SUB_W  (SUB_W)
    ) u_pick (
        .word (rd_word),
        .sel  (st_q.s1.col[SUB_W-1:0]),
        .idx  (pick_idx)
    );

    always_comb begin
        st_d = st_q;

        if (misc_we) begin
            if (misc_sel == IDX_W'(HWC_POS_SEL)) begin
                st_d.pos = reg_wdata[2*COORD_W-1:0];
            end else begin
                st_d.colour[IDX_W'(misc_sel - 1'b1)] = reg_wdata[COLOR_W-1:0];
            end
        end

        st_d.s1.valid = pix_valid;
        st_d.s1.hit   = hit_w;
        st_d.s1.col   = col_w;
        st_d.s1.row   = row_w;
        st_d.s1.bg    = pix_bg;

        st_d.out_valid = st_q.s1.valid;
        if (st_q.s1.hit && (pick_idx != '0)) begin
            st_d.out_pixel = st_q.colour[IDX_W'(pick_idx - 1'b1)];
        end else begin
            st_d.out_pixel = st_q.s1.bg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_valid;
    assign out_pixel = st_q.out_pixel;

    // Assertions

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && (out_pixel == '0)));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(st_q.s1.valid));

    a_r3_miss_passes_bg: assert property (@(posedge clk) disable iff (rst)
        (st_q.s1.valid && !st_q.s1.hit) |=> (out_pixel == $past(st_q.s1.bg)));

    a_r4_zero_transparent: assert property (@(posedge clk) disable iff (rst)
        (st_q.s1.valid && st_q.s1.hit && (pick_idx == '0))
        |=> (out_pixel == $past(st_q.s1.bg)));

    a_r5_colour_replace: assert property (@(posedge clk) disable iff (rst)
        (st_q.s1.valid && st_q.s1.hit && (pick_idx != '0))
        |=> (out_pixel == $past(st_q.colour[IDX_W'(pick_idx - 1'b1)])));

    a_r8_gated_off: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && (disp_ctrl[DATA_W-1:EN_LSB] != '0)) |=> !st_q.s1.hit);

endmodule

// File: tb/hwc_overlay_test.sv
module hwc_overlay_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [9:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] disp_ctrl;
    logic        pix_valid;
    logic [11:0] pix_x, pix_y;
    logic [23:0] pix_bg;
    logic        out_valid;
    logic [23:0] out_pixel;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    localparam logic [23:0] C1  = 24'h0000FF;
    localparam logic [23:0] C2  = 24'h00FF00;
    localparam logic [23:0] C3  = 24'hFF0000;
    localparam logic [23:0] BGA = 24'h5A5A5A;
    localparam logic [23:0] BGB = 24'h123456;

    always #2.5 clk = ~clk;

    hwc_overlay uut (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .disp_ctrl (disp_ctrl),
        .pix_valid (pix_valid),
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .pix_bg    (pix_bg),
        .out_valid (out_valid),
        .out_pixel (out_pixel)
    );

    typedef struct packed {
        logic [11:0] rx;
        logic [11:0] ry;
        logic [23:0] bg;
        logic [23:0] exp;
        logic [3:0]  req;
    } vec_t;

    // Cursor at (100,50). Word 0 = E4E4, word 42 = 0024, word 511 = C000.
    localparam vec_t VECS [13] = '{
        '{12'd100, 12'd50,  BGA, BGA, 4'd4},  // R4 pixel 0, index 0
        '{12'd101, 12'd50,  BGA, C1,  4'd5},  // R5 index 1
        '{12'd102, 12'd50,  BGB, C2,  4'd5},  // R5 index 2
        '{12'd103, 12'd50,  BGA, C3,  4'd6},  // R6 pair 3
        '{12'd107, 12'd50,  BGB, C3,  4'd6},  // R6 top pair of word
        '{12'd163, 12'd113, BGA, C3,  4'd9},  // R9 last pixel inside
        '{12'd164, 12'd113, BGA, BGA, 4'd9},  // R9 one past right edge
        '{12'd163, 12'd114, BGB, BGB, 4'd9},  // R9 one past bottom edge
        '{12'd99,  12'd50,  BGA, BGA, 4'd9},  // R9 one left of cursor
        '{12'd117, 12'd55,  BGA, C1,  4'd6},  // R6 line stride, word 42
        '{12'd118, 12'd55,  BGB, C2,  4'd6},  // R6
        '{12'd116, 12'd55,  BGB, BGB, 4'd4},  // R4
        '{12'd0,   12'd0,   BGA, BGA, 4'd3}   // R3 far outside
    };

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    // Present one pixel and return the result two edges later.
    task automatic probe(input logic [11:0] x, input logic [11:0] y,
                         input logic [23:0] bg, output logic [23:0] res);
        @(negedge clk);
        pix_valid = 1'b1;
        pix_x     = x;
        pix_y     = y;
        pix_bg    = bg;
        @(negedge clk);
        pix_valid = 1'b0;
        @(negedge clk);
        res = out_pixel;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected done");
        finish_run();
    end

    initial begin
        logic [23:0] res;
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        disp_ctrl = '0; pix_valid = 1'b0; pix_x = '0; pix_y = '0; pix_bg = '0;
        repeat (3) @(negedge clk);
        // R1 outputs held at zero during reset
        check("R1 out_valid in reset", {23'd0, out_valid}, 24'd0);
        check("R1 out_pixel in reset", out_pixel, 24'd0);
        rst = 1'b0;

        // R1 position and colours cleared: cursor at (0,0), colour 1 is zero
        wr(10'h000, 32'h0000_0001);
        probe(12'd0, 12'd0, BGA, res);
        check("R1 colour reset value", res, 24'd0);

        // R2 latency and valid delay
        @(negedge clk);
        pix_valid = 1'b1; pix_x = 12'd2000; pix_y = 12'd2000; pix_bg = BGB;
        @(negedge clk);
        pix_valid = 1'b0;
        check("R2 valid after one edge", {23'd0, out_valid}, 24'd0);
        @(negedge clk);
        check("R2 valid after two edges", {23'd0, out_valid}, 24'd1);
        check("R2 pixel after two edges", out_pixel, BGB);
        @(negedge clk);
        check("R2 valid drops", {23'd0, out_valid}, 24'd0);

        // Load cursor: colours, position (100,50), pattern words
        wr(10'h201, {8'h00, C1});
        wr(10'h202, {8'h00, C2});
        wr(10'h203, {8'h00, C3});
        wr(10'h200, {8'h00, 12'd100, 12'd50});
        wr(10'h000, 32'h0000_E4E4);
        wr(10'h02A, 32'h0000_0024);
        wr(10'h1FF, 32'h0000_C000);

        for (int i = 0; i < 13; i++) begin
            probe(VECS[i].rx, VECS[i].ry, VECS[i].bg, res);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), res, VECS[i].exp);
        end

        // R8 gate bits
        disp_ctrl = 32'h0080_0000;
        probe(12'd101, 12'd50, BGA, res);
        check("R8 bit 23 set hides cursor", res, BGA);
        disp_ctrl = 32'h8000_0000;
        probe(12'd103, 12'd50, BGB, res);
        check("R8 bit 31 set hides cursor", res, BGB);
        disp_ctrl = 32'h007F_FFFF;
        probe(12'd101, 12'd50, BGA, res);
        check("R8 low bits do not gate", res, C1);
        disp_ctrl = '0;

        // R10 unmapped misc address ignored
        wr(10'h205, 32'h00AB_CDEF);
        wr(10'h3FD, 32'h00AB_CDEF);
        probe(12'd101, 12'd50, BGA, res);
        check("R10 unmapped write ignored", res, C1);

        // R7 negative position (-2,-1): raster (0,0) is line 1, column 2
        wr(10'h008, 32'h0000_0030);
        wr(10'h200, {8'h00, 12'hFFE, 12'hFFF});
        probe(12'd0, 12'd0, BGA, res);
        check("R7 negative position hit", res, C3);
        probe(12'd1, 12'd0, BGB, res);
        check("R7 negative position index 0", res, BGB);
        probe(12'd61, 12'd62, BGA, res);
        check("R7 last visible pixel maps to word 511", res, C3);
        probe(12'd62, 12'd0, BGA, res);
        check("R9 right edge with negative x", res, BGA);

        finish_run();
    end

endmodule